// File: doc/BRIEF.md
# Configurable Order-Selectable Deserializer

This block gathers a serial bit stream into parallel words. On each clock with the valid strobe high it accepts one bit. It hands out a completed word on a 16-bit bus, with a one-cycle word-valid pulse and a divided parallel clock enable that rises with each new word.

Two static controls shape the words. The width control picks 4-bit or 16-bit words. In 4-bit mode only the low nibble of the bus carries data and the upper twelve bits are zero. The order control decides whether the first bit of a word lands on the lowest or the highest bit in use. A change of either control throws away any partly gathered word and starts counting afresh.

Top module: `ordsel_deser`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets par_word to 0 and word_vld and par_ce low, and discards all gathered bits.
- R2: With wide_mode = 0 a word is 4 accepted bits, and par_word[15:4] is 0 whenever such a word is presented.
- R3: With wide_mode = 1 a word is 16 accepted bits, and all of par_word[15:0] carries it.
- R4: With msb_first = 0 the k-th accepted bit of a word (k = 0 for the first) appears on par_word[k].
- R5: With msb_first = 1 the k-th accepted bit of a word appears on par_word[W-1-k], where W is 4 or 16.
- R6: A clock with ser_vld low accepts no bit and does not advance the word.
- R7: word_vld is high for exactly the one cycle after the edge that accepts the last bit of a word, and par_word changes only at that edge.
- R8: par_ce goes high at the same edge as word_vld and goes low at the edge that accepts bit number W/2 of the following word. It is therefore a clock-enable divided by W under a steady stream.
- R9: At any edge where wide_mode or msb_first differs from its value at the previous edge, the bit offered there and any partial word are discarded, no word is completed, par_ce goes low and par_word is held. Counting restarts with the next accepted bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_bit | input | 1 | Serial data bit |
| ser_vld | input | 1 | Qualifies ser_bit for this clock |
| wide_mode | input | 1 | 1 selects 16-bit words, 0 selects 4-bit words |
| msb_first | input | 1 | 1 maps the first bit to the top used bit, 0 to bit 0 |
| par_word | output | 16 | Last completed word |
| word_vld | output | 1 | One-cycle pulse when par_word is updated |
| par_ce | output | 1 | Divided parallel clock enable, rising with each word |

## Verification
A control change and the completion of a word can land on the same edge. The bench provokes this by feeding a word up to its final bit and then toggling the order or width control together with a valid bit. The change must win: no word_vld pulse follows, par_word keeps its earlier value, and the next word is gathered from scratch. A behavioural model built on a bit queue judges this, and a bound property checks that no word is reported right after a control change.

// File: rtl/ordsel_deser.sv
module ordsel_deser #(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic              ser_vld,
  input  logic              wide_mode,
  input  logic              msb_first,
  output logic [WIDE_W-1:0] par_word,
  output logic              word_vld,
  output logic              par_ce
);
  localparam int CW = $clog2(WIDE_W);

  logic [CW-1:0]     cnt;
  logic [WIDE_W-1:0] acc, acc_nxt;
  logic              mode_q, order_q;

  wire          cfg_chg = (wide_mode != mode_q) || (msb_first != order_q);
  wire [CW-1:0] last    = wide_mode ? CW'(WIDE_W - 1) : CW'(NARROW_W - 1);
  wire [CW-1:0] half    = wide_mode ? CW'(WIDE_W / 2 - 1) : CW'(NARROW_W / 2 - 1);
  wire [CW-1:0] pos     = msb_first ? last - cnt : cnt;

  always_comb begin
    acc_nxt      = acc;
    acc_nxt[pos] = ser_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      acc      <= '0;
      par_word <= '0;
      word_vld <= 1'b0;
      par_ce   <= 1'b0;
      mode_q   <= wide_mode;
      order_q  <= msb_first;
    end else begin
      mode_q   <= wide_mode;
      order_q  <= msb_first;
      word_vld <= 1'b0;
      if (cfg_chg) begin
        cnt    <= '0;
        acc    <= '0;
        par_ce <= 1'b0;
      end else if (ser_vld) begin
        if (cnt == last) begin
          par_word <= acc_nxt;
          word_vld <= 1'b1;
          par_ce   <= 1'b1;
          cnt      <= '0;
          acc      <= '0;
        end else begin
          acc <= acc_nxt;
          cnt <= cnt + 1'b1;
          if (cnt == half) par_ce <= 1'b0;
        end
      end
    end
  end
endmodule

module ordsel_deser_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wide_mode,
  input logic         msb_first,
  input logic [W-1:0] par_word,
  input logic         word_vld,
  input logic         par_ce
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (par_word == '0 && !word_vld && !par_ce));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

  // R7
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !word_vld) |-> $stable(par_word));

  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && $past(!wide_mode)) |-> (par_word[W-1:4] == '0));

  // R8
  ce_with_word_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> par_ce);

  // R9
  cfg_change_chk: assert property (@(posedge clk) disable iff (rst)
    (wide_mode != $past(wide_mode) || msb_first != $past(msb_first)) |=> (!word_vld && !par_ce));
endmodule

bind ordsel_deser ordsel_deser_chk #(.W(WIDE_W)) u_chk (
  .clk(clk), .rst(rst), .wide_mode(wide_mode), .msb_first(msb_first),
  .par_word(par_word), .word_vld(word_vld), .par_ce(par_ce)
);

// File: tb/tb_ordsel_deser.sv
module tb_ordsel_deser;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, ser_bit = 1'b0, ser_vld = 1'b0, wide_mode = 1'b0, msb_first = 1'b0;
  wire [15:0] par_word;
  wire        word_vld, par_ce;

  ordsel_deser dut (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_vld(ser_vld),
    .wide_mode(wide_mode), .msb_first(msb_first),
    .par_word(par_word), .word_vld(word_vld), .par_ce(par_ce)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  bit          q[$];
  logic        pm = 1'b0, po = 1'b0;
  logic [15:0] ew = '0;
  logic        ev = 1'b0, ec = 1'b0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(logic b, logic v, logic m, logic o, logic r);
    int w;
    w = m ? 16 : 4;
    if (r) begin
      q.delete(); ew = '0; ev = 1'b0; ec = 1'b0;
    end else if (m != pm || o != po) begin
      q.delete(); ev = 1'b0; ec = 1'b0;
    end else if (v) begin
      q.push_back(b);
      if (q.size() == w) begin
        ew = '0;
        for (int i = 0; i < w; i++) ew[o ? w - 1 - i : i] = q[i];
        ev = 1'b1; ec = 1'b1;
        q.delete();
      end else begin
        ev = 1'b0;
        if (q.size() == w / 2) ec = 1'b0;
      end
    end else ev = 1'b0;
    pm = m; po = o;
  endtask

  task automatic step(string tag, logic b, logic v, logic m, logic o, logic r = 1'b0);
    @(negedge clk);
    ser_bit = b; ser_vld = v; wide_mode = m; msb_first = o; rst = r;
    @(posedge clk);
    #1;
    model(b, v, m, o, r);
    chk({tag, " word"}, par_word, ew);
    chk({tag, " vld"}, {15'b0, word_vld}, {15'b0, ev});
    chk({tag, " ce"}, {15'b0, par_ce}, {15'b0, ec});
  endtask

  task automatic send(string tag, logic [15:0] val, int n, logic m, logic o);
    for (int i = 0; i < n; i++) step(tag, val[i], 1'b1, m, o);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step("R1 reset", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R1 reset word", par_word, 16'h0000);

    send("R2 R4 narrow lsb", 16'h000B, 4, 1'b0, 1'b0);
    chk("R4 narrow lsb value", par_word, 16'h000B);
    chk("R7 pulse", {15'b0, word_vld}, 16'h0001);
    step("R7 after", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 pulse ends", {15'b0, word_vld}, 16'h0000);

    step("R9 switch", 1'b1, 1'b1, 1'b0, 1'b1);
    send("R5 narrow msb", 16'h000B, 4, 1'b0, 1'b1);
    chk("R5 narrow msb value", par_word, 16'h000D);

    step("R9 switch", 1'b0, 1'b0, 1'b1, 1'b0);
    send("R3 R4 wide lsb", 16'hA5C3, 16, 1'b1, 1'b0);
    chk("R3 wide lsb value", par_word, 16'hA5C3);
    send("R8 half", 16'h00FF, 8, 1'b1, 1'b0);
    chk("R8 ce low at half", {15'b0, par_ce}, 16'h0000);
    send("R8 rest", 16'h0000, 8, 1'b1, 1'b0);

    step("R9 switch", 1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++) step("R5 wide msb", 1'(16'h3C96 >> (15 - i)), 1'b1, 1'b1, 1'b1);
    chk("R5 wide msb value", par_word, 16'h3C96);

    step("R9 switch", 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 upper zero kept after wide", par_word, 16'h3C96);
    for (int i = 0; i < 4; i++) begin
      step("R6 gap", 1'b1, 1'b0, 1'b0, 1'b0);
      step("R6 bit", 1'b0, 1'b1, 1'b0, 1'b0);
    end
    chk("R6 gaps ignored", par_word, 16'h0000);
    chk("R2 narrow upper zero", {4'b0, par_word[15:4]}, 16'h0000);

    send("R9 partial", 16'h0007, 3, 1'b0, 1'b0);
    step("R9 change on last", 1'b1, 1'b1, 1'b0, 1'b1);
    chk("R9 no word on change", {15'b0, word_vld}, 16'h0000);
    chk("R9 word held", par_word, 16'h0000);
    send("R9 restart", 16'h0001, 4, 1'b0, 1'b1);
    chk("R9 restart value", par_word, 16'h0008);

    for (int i = 0; i < 3000; i++) begin
      logic m, o;
      m = wide_mode; o = msb_first;
      if ($urandom % 60 == 0) m = ~m;
      if ($urandom % 60 == 0) o = ~o;
      step("R7 R8 random", 1'($urandom), ($urandom % 4) != 0, m, o, ($urandom % 1500) == 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule